// File: doc/BRIEF.md
# Table-Stepped PWM Waveform Sequencer

This block is one PWM channel whose high time and/or period are taken from an on-chip byte table. The table changes these values over time, so the output traces a programmed waveform such as a breathing or ramping brightness curve. A write port fills the table. The table can be read as plain bytes or as 16-bit values built from byte pairs.

An address sequencer walks the table between a lower and an upper index. It starts at a programmed offset above the lower index. Each entry is held for a programmed number of PWM periods, with extra periods spent at the turning points and at a middle index. The walk either wraps from top to bottom or sweeps up and down. One-cycle pulses flag arrival at the middle and upper indices, so software can refill the table half by half.

The block runs until `run` is dropped, or in one-shot operation it stops by itself after a set number of sweeps. Configuration inputs are expected to stay stable while `busy` is high. The exceptions are the static duty and period values, the source selects and the table write port, which may change at any time.

Top module: `wtab_pwm`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pwm_out`, `irq_mid`, `irq_max`, `busy` and `done` are all 0 after that edge.
- R2: Table entry k reads as byte k, zero-extended to 16 bits, when `wide_mode`=0. It reads as {byte 2k+1, byte 2k} when `wide_mode`=1. Bytes beyond the table read as 0. A byte is written at a clock edge where `wr_en`=1.
- R3: A period with period value P lasts max(P,1) clocks. The output is high during the first D clocks of the period and low for the rest. When D ≥ P it stays high for the whole period.
- R4: Duty is taken from the table when `duty_from_tbl`=1, and period when `per_from_tbl`=1. A quantity that is not table-driven uses `static_duty` / `static_per`. Any new value is adopted only at the start of a period.
- R5: The clock edge with `run`=1 while idle starts the sequence at entry (`idx_min`+`idx_ofs`) mod 2^ADDR_W with counter 0. Each entry is held for max(`rpt`,1) periods plus any hold.
- R6: With `pingpong`=0, the entry after `idx_max` (or any index above it) is `idx_min`; otherwise the index increments. Each wrap counts as one completed sweep.
- R7: With `pingpong`=1, the index rises to `idx_max` and then falls. At `idx_max` it moves to `idx_max`−1, or stays at `idx_min` if the two are equal. At `idx_min` while falling it moves to `idx_min`+1, and that turn counts as one completed sweep.
- R8: An entry at `idx_max` is held for `hold_max` extra periods. Otherwise, an entry at `idx_min` is held for `hold_min` extra periods. Otherwise, an entry at `idx_mid` is held for `hold_mid` extra periods.
- R9: `irq_mid` (`irq_max`) is high for the cycle after each entry load whose index equals `idx_mid` (`idx_max`), and only while `busy`.
- R10: With `oneshot`=1, the sequence ends at the period boundary that would complete sweep number max(`sweeps`,1). From then on `busy`=0, `pwm_out`=0 and `done`=1 until `run` falls. With `oneshot`=0 it runs on indefinitely.
- R11: A clock edge with `run`=0 makes `busy`, `done`, `pwm_out` and both interrupts 0 after that edge.
- R12: A table value is captured only when its entry is loaded. A write landing on the same edge as a load of that byte is not seen by that load; it is seen by the next load of the entry.
- R13: The period value is read from table entry (current index + `per_gap`), with no wrap at the index width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table byte write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | BYTE_W | Byte written |
| run | input | 1 | Start / keep running; low stops at once |
| wide_mode | input | 1 | 0: byte entries, 1: 16-bit entries from byte pairs |
| pingpong | input | 1 | 0: wrap walk, 1: up/down walk |
| oneshot | input | 1 | Stop after `sweeps` sweeps |
| duty_from_tbl | input | 1 | Duty taken from the table |
| per_from_tbl | input | 1 | Period taken from the table |
| static_duty | input | 2*BYTE_W | Duty when not table-driven |
| static_per | input | 2*BYTE_W | Period when not table-driven |
| idx_min | input | ADDR_W | Lower entry index |
| idx_max | input | ADDR_W | Upper entry index |
| idx_mid | input | ADDR_W | Middle entry index |
| idx_ofs | input | ADDR_W | Start offset above `idx_min` |
| per_gap | input | ADDR_W | Distance from duty entry to period entry |
| rpt | input | RPT_W | Periods per entry |
| hold_max | input | HOLD_W | Extra periods at `idx_max` |
| hold_min | input | HOLD_W | Extra periods at `idx_min` |
| hold_mid | input | HOLD_W | Extra periods at `idx_mid` |
| sweeps | input | SWEEP_W | One-shot sweep count |
| pwm_out | output | 1 | PWM waveform |
| irq_mid | output | 1 | Pulse on loading the middle entry |
| irq_max | output | 1 | Pulse on loading the upper entry |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-shot sequence finished |

## Verification
The waveform core is first tried on static values: a duty below the period, a duty at or above it, and a zero period. This separates the compare edge from the period length. Table-driven runs then use byte mode and pair mode with a high byte set, which exposes byte-order and zero-extension faults. Separate duty and period entries catch a wrong period offset.

Wrap and up/down walks with unequal hold counts at all three marked indices, plus a start offset and several repeat counts, separate the address orderings and the dwell arithmetic. One-shot runs with two sweeps and with a zero sweep count check the stop point. Dropping `run` in mid-period checks the stop path. Table writes hammered onto the single entry being reloaded distinguish the old value from the new one at each load.

// File: rtl/wtp_pkg.sv
// Package: shared definitions for the table-stepped PWM sequencer.
// Assumes nothing beyond standard SystemVerilog.
package wtp_pkg;

    // Number of simultaneous table read ports (duty entry, period entry).
    localparam int RD_PORTS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/wtp_table.sv
// Wave table: byte-wide storage with one write port and RD_PORTS
// asynchronous read ports. Each read port returns an entry either as
// a zero-extended byte or as a little-endian byte pair.
// Assumes: entry indices may exceed the table; such bytes read as 0.
// The storage itself is not reset; it must be written before use.
module wtp_table
    import wtp_pkg::*;
#(
    parameter int TBL_BYTES = 768,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 10,
    parameter int IDX_W     = ADDR_W + 1,
    parameter int VAL_W     = 2 * BYTE_W
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [BYTE_W-1:0]              wr_data,
    input  logic                           wide_mode,
    input  logic [RD_PORTS-1:0][IDX_W-1:0] rd_idx,
    output logic [RD_PORTS-1:0][VAL_W-1:0] rd_val
);
    localparam int BA_W = IDX_W + 1;
    localparam logic [BA_W-1:0]   LIMIT_BA = BA_W'(TBL_BYTES);
    localparam logic [ADDR_W-1:0] LIMIT_WA = ADDR_W'(TBL_BYTES);

    logic [BYTE_W-1:0] mem [TBL_BYTES];

    // Byte write into the table.
    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < LIMIT_WA)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        logic [BA_W-1:0]   lo_ba;
        logic [BA_W-1:0]   hi_ba;
        logic [BYTE_W-1:0] lo_byte;
        logic [BYTE_W-1:0] hi_byte;

        // Entry-to-byte address mapping and out-of-range guard.
        always_comb begin
            lo_ba   = wide_mode ? {rd_idx[p], 1'b0} : {1'b0, rd_idx[p]};
            hi_ba   = lo_ba + BA_W'(1);
            lo_byte = (lo_ba < LIMIT_BA) ? mem[lo_ba[ADDR_W-1:0]] : '0;
            hi_byte = (hi_ba < LIMIT_BA) ? mem[hi_ba[ADDR_W-1:0]] : '0;
            rd_val[p] = wide_mode ? {hi_byte, lo_byte}
                                  : {{(VAL_W-BYTE_W){1'b0}}, lo_byte};
        end
    end

endmodule

// File: rtl/wtp_addr_seq.sv
// Address sequencer: walks table indices between idx_min and idx_max,
// holds each entry for a repeat count plus turning-point holds, counts
// sweeps for one-shot stop and raises middle / maximum pulses.
// Assumes: the index inputs stay stable while running; period_end is
// the last clock of the current PWM period from the waveform core.
module wtp_addr_seq
    import wtp_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int RPT_W   = 8,
    parameter int HOLD_W  = 8,
    parameter int SWEEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pingpong,
    input  logic              oneshot,
    input  logic [ADDR_W-1:0] idx_min,
    input  logic [ADDR_W-1:0] idx_max,
    input  logic [ADDR_W-1:0] idx_mid,
    input  logic [ADDR_W-1:0] idx_ofs,
    input  logic [RPT_W-1:0]  rpt,
    input  logic [HOLD_W-1:0] hold_max,
    input  logic [HOLD_W-1:0] hold_min,
    input  logic [HOLD_W-1:0] hold_mid,
    input  logic [SWEEP_W-1:0] sweeps,
    input  logic              period_end,
    output logic              active,
    output logic              done,
    output logic              start,
    output logic              load,
    output logic [ADDR_W-1:0] load_idx,
    output logic [ADDR_W-1:0] cur_idx,
    output logic              irq_mid,
    output logic              irq_max
);
    localparam int DW_W = ((RPT_W > HOLD_W) ? RPT_W : HOLD_W) + 1;

    seq_state_e          state;
    logic [ADDR_W-1:0]   idx;
    logic                going_down;
    logic [DW_W-1:0]     rep;
    logic [SWEEP_W-1:0]  swept;

    logic [ADDR_W-1:0]   start_idx;
    logic [ADDR_W-1:0]   nxt_idx;
    logic                nxt_down;
    logic                wrapped;
    logic [HOLD_W-1:0]   hold_sel;
    logic [DW_W-1:0]     dwell;
    logic                boundary;
    logic                step;
    logic [SWEEP_W-1:0]  sweep_goal;
    logic                last_sweep;
    logic                finish;

    // Dwell length of the current entry: repeat count plus its hold.
    always_comb begin
        if (idx == idx_max)      hold_sel = hold_max;
        else if (idx == idx_min) hold_sel = hold_min;
        else if (idx == idx_mid) hold_sel = hold_mid;
        else                     hold_sel = '0;
        dwell = ((rpt == '0) ? DW_W'(1) : DW_W'(rpt)) + DW_W'(hold_sel);
    end

    // Next index and direction for wrap and up/down walks.
    always_comb begin
        nxt_idx  = idx;
        nxt_down = 1'b0;
        wrapped  = 1'b0;
        if (!pingpong) begin
            if (idx >= idx_max) begin
                nxt_idx = idx_min;
                wrapped = 1'b1;
            end else begin
                nxt_idx = idx + ADDR_W'(1);
            end
        end else if (!going_down) begin
            if (idx >= idx_max) begin
                nxt_idx  = (idx_max > idx_min) ? idx_max - ADDR_W'(1) : idx_min;
                nxt_down = 1'b1;
            end else begin
                nxt_idx = idx + ADDR_W'(1);
            end
        end else begin
            if (idx <= idx_min) begin
                nxt_idx = (idx_max > idx_min) ? idx_min + ADDR_W'(1) : idx_min;
                wrapped = 1'b1;
            end else begin
                nxt_idx  = idx - ADDR_W'(1);
                nxt_down = 1'b1;
            end
        end
    end

    // Start, step, stop and load decisions for this cycle.
    always_comb begin
        start_idx  = idx_min + idx_ofs;
        start      = run && (state == ST_IDLE);
        boundary   = (state == ST_RUN) && period_end;
        step       = boundary && ((rep + DW_W'(1)) >= dwell);
        sweep_goal = (sweeps == '0) ? SWEEP_W'(1) : sweeps;
        last_sweep = ({1'b0, swept} + (SWEEP_W+1)'(1)) >= {1'b0, sweep_goal};
        finish     = step && wrapped && oneshot && last_sweep;
        load       = start || (step && !finish);
        load_idx   = start ? start_idx : nxt_idx;
    end

    // Sequencer state, index, direction, repeat and sweep registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state      <= ST_IDLE;
            idx        <= '0;
            going_down <= 1'b0;
            rep        <= '0;
            swept      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state      <= ST_RUN;
                    idx        <= start_idx;
                    going_down <= 1'b0;
                    rep        <= '0;
                    swept      <= '0;
                end
                ST_RUN: begin
                    if (finish) begin
                        state <= ST_DONE;
                    end else if (step) begin
                        idx        <= nxt_idx;
                        going_down <= nxt_down;
                        rep        <= '0;
                        if (wrapped) swept <= swept + SWEEP_W'(1);
                    end else if (boundary) begin
                        rep <= rep + DW_W'(1);
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    // Middle / maximum arrival pulses, one cycle after each load.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            irq_mid <= 1'b0;
            irq_max <= 1'b0;
        end else begin
            irq_mid <= load && (load_idx == idx_mid);
            irq_max <= load && (load_idx == idx_max);
        end
    end

    assign active  = (state == ST_RUN);
    assign done    = (state == ST_DONE);
    assign cur_idx = idx;

endmodule

// File: rtl/wtp_pwm_core.sv
// Waveform core: period counter and duty compare. Table values are
// captured at each entry load; the values in use switch only at a
// period start, so a running period is never cut short.
// Assumes: start and load come from the sequencer in the same cycle.
module wtp_pwm_core #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             start,
    input  logic             load,
    input  logic [VAL_W-1:0] tbl_duty,
    input  logic [VAL_W-1:0] tbl_per,
    input  logic             duty_from_tbl,
    input  logic             per_from_tbl,
    input  logic [VAL_W-1:0] static_duty,
    input  logic [VAL_W-1:0] static_per,
    output logic             period_end,
    output logic             pwm_out
);
    logic [VAL_W-1:0] cnt;
    logic [VAL_W-1:0] ent_duty;
    logic [VAL_W-1:0] ent_per;
    logic [VAL_W-1:0] cur_duty;
    logic [VAL_W-1:0] cur_per;
    logic [VAL_W-1:0] ent_duty_n;
    logic [VAL_W-1:0] ent_per_n;
    logic [VAL_W-1:0] per_last;

    // Fetched entry values and period end detect.
    always_comb begin
        ent_duty_n = load ? tbl_duty : ent_duty;
        ent_per_n  = load ? tbl_per  : ent_per;
        per_last   = (cur_per == '0) ? '0 : cur_per - VAL_W'(1);
        period_end = (cnt >= per_last);
    end

    // Capture table values at each entry load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_duty <= '0;
            ent_per  <= '0;
        end else if (load) begin
            ent_duty <= tbl_duty;
            ent_per  <= tbl_per;
        end
    end

    // Period counter, cleared at start and at every period end.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || period_end) cnt <= '0;
        else                                 cnt <= cnt + VAL_W'(1);
    end

    // Values in use, switched only at a period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_duty <= '0;
            cur_per  <= '0;
        end else if (start || (active && period_end)) begin
            cur_duty <= duty_from_tbl ? ent_duty_n : static_duty;
            cur_per  <= per_from_tbl  ? ent_per_n  : static_per;
        end
    end

    assign pwm_out = active && (cnt < cur_duty);

endmodule

// File: rtl/wtab_pwm.sv
// Top: table-stepped PWM channel. Connects the wave table, the address
// sequencer and the waveform core. Duty is read at the current entry
// and period at the entry per_gap further on.
// Assumes: index, mode and repeat inputs are stable while busy.
module wtab_pwm
    import wtp_pkg::*;
#(
    parameter int TBL_BYTES = 768,
    parameter int BYTE_W    = 8,
    parameter int RPT_W     = 8,
    parameter int HOLD_W    = 8,
    parameter int SWEEP_W   = 8,
    parameter int ADDR_W    = $clog2(TBL_BYTES),
    parameter int VAL_W     = 2 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               run,
    input  logic               wide_mode,
    input  logic               pingpong,
    input  logic               oneshot,
    input  logic               duty_from_tbl,
    input  logic               per_from_tbl,
    input  logic [VAL_W-1:0]   static_duty,
    input  logic [VAL_W-1:0]   static_per,
    input  logic [ADDR_W-1:0]  idx_min,
    input  logic [ADDR_W-1:0]  idx_max,
    input  logic [ADDR_W-1:0]  idx_mid,
    input  logic [ADDR_W-1:0]  idx_ofs,
    input  logic [ADDR_W-1:0]  per_gap,
    input  logic [RPT_W-1:0]   rpt,
    input  logic [HOLD_W-1:0]  hold_max,
    input  logic [HOLD_W-1:0]  hold_min,
    input  logic [HOLD_W-1:0]  hold_mid,
    input  logic [SWEEP_W-1:0] sweeps,
    output logic               pwm_out,
    output logic               irq_mid,
    output logic               irq_max,
    output logic               busy,
    output logic               done
);
    localparam int IDX_W = ADDR_W + 1;

    logic                           seq_active;
    logic                           seq_start;
    logic                           seq_load;
    logic [ADDR_W-1:0]              seq_load_idx;
    logic [ADDR_W-1:0]              seq_idx;
    logic                           core_period_end;
    logic [RD_PORTS-1:0][IDX_W-1:0] tbl_idx;
    logic [RD_PORTS-1:0][VAL_W-1:0] tbl_val;

    // Read addresses: duty entry and period entry of the loading index.
    always_comb begin
        tbl_idx[0] = {1'b0, seq_load_idx};
        tbl_idx[1] = {1'b0, seq_load_idx} + {1'b0, per_gap};
    end

    wtp_table #(
        .TBL_BYTES (TBL_BYTES),
        .BYTE_W    (BYTE_W),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .VAL_W     (VAL_W)
    ) u_table (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wide_mode (wide_mode),
        .rd_idx    (tbl_idx),
        .rd_val    (tbl_val)
    );

    wtp_addr_seq #(
        .ADDR_W  (ADDR_W),
        .RPT_W   (RPT_W),
        .HOLD_W  (HOLD_W),
        .SWEEP_W (SWEEP_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .pingpong   (pingpong),
        .oneshot    (oneshot),
        .idx_min    (idx_min),
        .idx_max    (idx_max),
        .idx_mid    (idx_mid),
        .idx_ofs    (idx_ofs),
        .rpt        (rpt),
        .hold_max   (hold_max),
        .hold_min   (hold_min),
        .hold_mid   (hold_mid),
        .sweeps     (sweeps),
        .period_end (core_period_end),
        .active     (seq_active),
        .done       (done),
        .start      (seq_start),
        .load       (seq_load),
        .load_idx   (seq_load_idx),
        .cur_idx    (seq_idx),
        .irq_mid    (irq_mid),
        .irq_max    (irq_max)
    );

    wtp_pwm_core #(
        .VAL_W (VAL_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (seq_active),
        .start         (seq_start),
        .load          (seq_load),
        .tbl_duty      (tbl_val[0]),
        .tbl_per       (tbl_val[1]),
        .duty_from_tbl (duty_from_tbl),
        .per_from_tbl  (per_from_tbl),
        .static_duty   (static_duty),
        .static_per    (static_per),
        .period_end    (core_period_end),
        .pwm_out       (pwm_out)
    );

    assign busy = seq_active;

endmodule

// File: rtl/wtp_checker.sv
// Checker: temporal properties of the sequencer outputs, bound to the
// top module. Assumes the synchronous active-low reset of the top.
module wtp_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              busy,
    input logic              done,
    input logic              pwm_out,
    input logic              irq_mid,
    input logic              irq_max,
    input logic [ADDR_W-1:0] seq_idx,
    input logic [ADDR_W-1:0] idx_max
);
    // R3 / R10: no output pulse while not running.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pwm_out);

    // R10: finished and running never at once.
    assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R11: dropping run stops the sequence at the next edge.
    assert_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!busy && !done && !irq_mid && !irq_max));

    // R9: interrupt pulses only while running.
    assert_irq_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mid || irq_max) |-> busy);

    // R9: maximum pulse marks the index just loaded as the upper index.
    assert_irq_max_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_max |-> (seq_idx == $past(idx_max)));
endmodule

bind wtab_pwm wtp_checker #(.ADDR_W(ADDR_W)) u_wtp_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .busy    (busy),
    .done    (done),
    .pwm_out (pwm_out),
    .irq_mid (irq_mid),
    .irq_max (irq_max),
    .seq_idx (seq_idx),
    .idx_max (idx_max)
);

// File: tb/wtab_pwm_test.sv
// Bench: behavioural reference model stepped at every clock edge and
// compared with all outputs on every falling edge.
module wtab_pwm_test;
    localparam int NB  = 768;
    localparam int AW  = 10;
    localparam int IDXM = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        run = 1'b0, wide_mode = 1'b0, pingpong = 1'b0, oneshot = 1'b0;
    logic        duty_from_tbl = 1'b0, per_from_tbl = 1'b0;
    logic [15:0] static_duty = '0, static_per = '0;
    logic [9:0]  idx_min = '0, idx_max = '0, idx_mid = '0, idx_ofs = '0, per_gap = '0;
    logic [7:0]  rpt = '0, hold_max = '0, hold_min = '0, hold_mid = '0, sweeps = '0;
    logic        pwm_out, irq_mid, irq_max, busy, done;

    wtab_pwm uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .run(run), .wide_mode(wide_mode), .pingpong(pingpong), .oneshot(oneshot),
        .duty_from_tbl(duty_from_tbl), .per_from_tbl(per_from_tbl),
        .static_duty(static_duty), .static_per(static_per),
        .idx_min(idx_min), .idx_max(idx_max), .idx_mid(idx_mid), .idx_ofs(idx_ofs),
        .per_gap(per_gap), .rpt(rpt), .hold_max(hold_max), .hold_min(hold_min),
        .hold_mid(hold_mid), .sweeps(sweeps), .pwm_out(pwm_out), .irq_mid(irq_mid),
        .irq_max(irq_max), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Reference model state.
    int mem [NB];
    int m_st = 0, m_idx = 0, m_down = 0, m_rep = 0, m_sw = 0, m_cnt = 0;
    int m_ed = 0, m_ep = 0, m_cd = 0, m_cp = 0, m_im = 0, m_ix = 0;

    function automatic int tval(int k);
        int lo, b0, b1;
        if (!wide_mode) return (k < NB) ? mem[k] : 0;
        lo = 2 * k;
        b0 = (lo < NB) ? mem[lo] : 0;
        b1 = (lo + 1 < NB) ? mem[lo + 1] : 0;
        return b1 * 256 + b0;
    endfunction

    function automatic int hold_of(int k);
        if (k == int'(idx_max)) return int'(hold_max);
        if (k == int'(idx_min)) return int'(hold_min);
        if (k == int'(idx_mid)) return int'(hold_mid);
        return 0;
    endfunction

    task automatic m_fetch(int k);
        m_ed = tval(k);
        m_ep = tval(k + int'(per_gap));
        m_im = (k == int'(idx_mid)) ? 1 : 0;
        m_ix = (k == int'(idx_max)) ? 1 : 0;
    endtask

    // Model step at each rising edge, table write applied last.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_im = 0; m_ix = 0; m_cnt = 0; m_cd = 0; m_cp = 0;
        end else if (!run) begin
            m_st = 0; m_im = 0; m_ix = 0;
        end else if (m_st == 0) begin
            m_idx = (int'(idx_min) + int'(idx_ofs)) % IDXM;
            m_down = 0; m_rep = 0; m_sw = 0; m_cnt = 0;
            m_fetch(m_idx);
            m_cd = duty_from_tbl ? m_ed : int'(static_duty);
            m_cp = per_from_tbl ? m_ep : int'(static_per);
            m_st = 1;
        end else if (m_st == 1) begin
            m_im = 0; m_ix = 0;
            if (m_cnt >= ((m_cp == 0) ? 0 : m_cp - 1)) begin
                int dwell, nidx, ndown, wrap, goal;
                m_cnt = 0;
                dwell = ((rpt == 0) ? 1 : int'(rpt)) + hold_of(m_idx);
                if (m_rep + 1 >= dwell) begin
                    nidx = m_idx; ndown = 0; wrap = 0;
                    if (!pingpong) begin
                        if (m_idx >= int'(idx_max)) begin nidx = int'(idx_min); wrap = 1; end
                        else nidx = m_idx + 1;
                    end else if (m_down == 0) begin
                        if (m_idx >= int'(idx_max)) begin
                            nidx = (idx_max > idx_min) ? int'(idx_max) - 1 : int'(idx_min);
                            ndown = 1;
                        end else nidx = m_idx + 1;
                    end else begin
                        if (m_idx <= int'(idx_min)) begin
                            nidx = (idx_max > idx_min) ? int'(idx_min) + 1 : int'(idx_min);
                            wrap = 1;
                        end else begin nidx = m_idx - 1; ndown = 1; end
                    end
                    goal = (sweeps == 0) ? 1 : int'(sweeps);
                    if (wrap == 1 && oneshot && m_sw + 1 >= goal) begin
                        m_st = 2;
                    end else begin
                        m_idx = nidx; m_down = ndown; m_rep = 0;
                        if (wrap == 1) m_sw++;
                        m_fetch(m_idx);
                    end
                end else begin
                    m_rep++;
                end
                m_cd = duty_from_tbl ? m_ed : int'(static_duty);
                m_cp = per_from_tbl ? m_ep : int'(static_per);
            end else begin
                m_cnt++;
            end
        end
        if (wr_en && int'(wr_addr) < NB) mem[wr_addr] = int'(wr_data);
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        logic e_pwm, e_busy, e_done, e_im, e_ix;
        e_pwm  = (m_st == 1) && (m_cnt < m_cd);
        e_busy = (m_st == 1);
        e_done = (m_st == 2);
        e_im   = (m_im != 0);
        e_ix   = (m_ix != 0);
        checks++;
        if (pwm_out !== e_pwm || busy !== e_busy || done !== e_done ||
            irq_mid !== e_im || irq_max !== e_ix) begin
            errors++;
            $display("FAIL %s t=%0t actual pwm=%b busy=%b done=%b mid=%b max=%b expected pwm=%b busy=%b done=%b mid=%b max=%b",
                     cur_req, $time, pwm_out, busy, done, irq_mid, irq_max,
                     e_pwm, e_busy, e_done, e_im, e_ix);
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        cur_req = "R1";
        wait_cyc(4);
        rst_n = 1'b1;
        // R2: fill table; even bytes small, odd bytes 0, byte 41 = 1.
        cur_req = "R2";
        for (int a = 0; a < NB; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 10'(a);
            wr_data = (a == 41) ? 8'd1 : ((a % 2) != 0) ? 8'd0 : 8'((a % 11) + 1);
        end
        @(negedge clk); wr_en = 1'b0;
        // R3: static shape, duty below, at/above period, zero period.
        cur_req = "R3";
        static_duty = 16'd3; static_per = 16'd5; rpt = 8'd1;
        run = 1'b1; wait_cyc(40);
        cur_req = "R4";
        static_duty = 16'd9; static_per = 16'd4; wait_cyc(30);
        cur_req = "R3";
        static_duty = 16'd0; static_per = 16'd0; wait_cyc(10);
        static_duty = 16'd1; wait_cyc(10);
        run = 1'b0; wait_cyc(3);
        // R4: duty from table, static period, then period from table.
        cur_req = "R4";
        duty_from_tbl = 1'b1; static_per = 16'd12;
        idx_min = 10'd10; idx_max = 10'd14; idx_mid = 10'd12;
        run = 1'b1; wait_cyc(150);
        cur_req = "R13";
        per_from_tbl = 1'b1; per_gap = 10'd100; wait_cyc(150);
        run = 1'b0; wait_cyc(3);
        // R5: start offset and repeat count.
        cur_req = "R5";
        idx_ofs = 10'd2; rpt = 8'd3; run = 1'b1; wait_cyc(300);
        run = 1'b0; wait_cyc(3);
        // R6: wrap walk.
        cur_req = "R6";
        idx_ofs = 10'd0; idx_min = 10'd5; idx_max = 10'd8; idx_mid = 10'd6;
        rpt = 8'd1; per_gap = 10'd1; run = 1'b1; wait_cyc(200);
        run = 1'b0; wait_cyc(3);
        // R2: pair mode with a set high byte.
        cur_req = "R2";
        wide_mode = 1'b1; idx_min = 10'd20; idx_max = 10'd22; idx_mid = 10'd21;
        per_gap = 10'd3; rpt = 8'd2; run = 1'b1; wait_cyc(900);
        run = 1'b0; wait_cyc(3);
        // R7 / R8 / R9: up/down walk with holds and pulses.
        cur_req = "R7";
        wide_mode = 1'b0; pingpong = 1'b1;
        idx_min = 10'd4; idx_max = 10'd9; idx_mid = 10'd6;
        hold_max = 8'd2; hold_min = 8'd1; hold_mid = 8'd3; rpt = 8'd1; per_gap = 10'd50;
        run = 1'b1; wait_cyc(300);
        cur_req = "R8"; wait_cyc(300);
        cur_req = "R9"; wait_cyc(200);
        run = 1'b0; wait_cyc(3);
        // R10: one-shot, two sweeps wrap, then zero sweeps up/down.
        cur_req = "R10";
        hold_max = 8'd0; hold_min = 8'd0; hold_mid = 8'd0;
        oneshot = 1'b1; sweeps = 8'd2; pingpong = 1'b0;
        idx_min = 10'd3; idx_max = 10'd5; idx_mid = 10'd4; per_gap = 10'd0;
        run = 1'b1; wait_cyc(200);
        run = 1'b0; wait_cyc(3);
        sweeps = 8'd0; pingpong = 1'b1; run = 1'b1; wait_cyc(200);
        run = 1'b0; wait_cyc(3);
        // R11: stop in mid-period and restart.
        cur_req = "R11";
        oneshot = 1'b0; run = 1'b1; wait_cyc(7);
        run = 1'b0; wait_cyc(2);
        run = 1'b1; wait_cyc(13);
        run = 1'b0; wait_cyc(3);
        // R12: writes into the single entry being reloaded.
        cur_req = "R12";
        pingpong = 1'b0; idx_min = 10'd30; idx_max = 10'd30; idx_mid = 10'd30;
        per_from_tbl = 1'b0; static_per = 16'd4; rpt = 8'd1;
        run = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            wr_en = ((i % 3) != 1); wr_addr = 10'd30; wr_data = 8'((i * 37) % 7);
        end
        @(negedge clk); wr_en = 1'b0;
        wait_cyc(12);
        run = 1'b0; wait_cyc(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule